// File: doc/BRIEF.md
# Pin Boundary-Scan Chain

This block places one test cell at every chip pin and links the cells into a single serial register. It sits between the core and the pads. Input pins, output pins and bidirectional pins are supported. Each bidirectional pin gets two cells: one for its data and one that sets its drive direction. A separate test access controller supplies the capture, shift and update strobes and a test-mode select. All state is clocked by the test clock.

While test mode is off, every cell is a plain wire between core and pad. The core behaves as if the chain were absent. While test mode is on, values that were loaded serially and then committed drive the pads and the core-side inputs. Those committed values do not move while new data is shifted. Captured pin values can be read out serially at the chain's far end. The chain runs from the serial input through all input cells in ascending index order, then all output cells in ascending order, then, for each bidirectional pin in ascending order, its data cell followed by its enable cell.

Top module: `bsr_top`

## Requirements
- R1: With testMode low, padOut equals coreOut, padBiOut equals coreBiOut, padBiOe equals coreBiOe, coreIn equals padIn, and coreBiIn equals padBiIn, in the same cycle, whatever the chain holds.
- R2: At a rising tck edge with captureDr high, each cell's capture stage loads its own source: an input cell loads its padIn bit, an output cell loads its coreOut bit, a bidirectional data cell loads its padBiIn bit, and an enable cell loads its coreBiOe bit.
- R3: At a rising tck edge with shiftDr high and captureDr low, the chain advances one position. Chain position 0 takes tdi, and each other position takes the value of the position before it. Positions are numbered from tdi: inputs 0..NUM_IN-1, then outputs, then per bidirectional pin its data cell and then its enable cell. tdo always shows the capture stage of the last position.
- R4: At a rising tck edge with updateDr high, every update stage loads its own cell's capture stage value.
- R5: Update stages change only on updateDr. While capture or shift runs, pad drives, enables and core-side inputs stay unchanged.
- R6: With testMode high, padOut shows the output cells' update values, and coreIn shows the input cells' update values.
- R7: With testMode high, padBiOut shows each bidirectional data cell's update value, and padBiOe shows its enable cell's update value (1 = drive the pad).
- R8: When captureDr and shiftDr are both high at an edge, the capture load wins and no shift occurs.
- R9: With captureDr and shiftDr both low, the capture stages and tdo hold their value.
- R10: While trstN is low, all capture and update stages clear to 0. In test mode this drives every pad output and core-side input low and every output enable off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous test reset, active low |
| tdi | input | 1 | Serial data into chain position 0 |
| captureDr | input | 1 | Capture strobe |
| shiftDr | input | 1 | Shift strobe |
| updateDr | input | 1 | Update strobe |
| testMode | input | 1 | 1 = cells drive from update stages |
| coreOut | input | NUM_OUT | Functional output values from the core |
| padIn | input | NUM_IN | Values arriving at the input pads |
| coreBiOut | input | NUM_BIDIR | Functional data for bidirectional pads |
| coreBiOe | input | NUM_BIDIR | Functional output enables for bidirectional pads |
| padBiIn | input | NUM_BIDIR | Values seen at the bidirectional pads |
| padOut | output | NUM_OUT | Drive values to the output pads |
| padBiOut | output | NUM_BIDIR | Drive values to the bidirectional pads |
| padBiOe | output | NUM_BIDIR | Output enables to the bidirectional pads |
| coreIn | output | NUM_IN | Input-pin values presented to the core |
| coreBiIn | output | NUM_BIDIR | Bidirectional pad values presented to the core |
| tdo | output | 1 | Serial data from the last chain position |

## Verification
The checker watches four things on every cycle. It checks pass-through of all functional signals while test mode is off. It checks that pad drives and enables hold steady in test mode unless an update strobe arrives. It checks that tdo holds when neither capture nor shift is active. It checks that tdo shows the last enable cell's source right after a capture. Three things need the bench's scenarios: the full serial order of the chain, the mapping of every chain position to its pin after an update, and the precedence of capture over a simultaneous shift. Those scenarios capture known pin patterns, shift them out against a queue of expected bits while new patterns go in, and commit the new values.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  // Strobes from the control half to the cell datapath.
  typedef struct packed {
    logic capture;  // parallel load of capture stages
    logic shift;    // serial advance of capture stages
    logic update;   // commit capture stages into update stages
    logic testOn;   // update stages own the pads and core inputs
  } bsrStrobes_t;
endpackage

// File: rtl/bsr_ctrl.sv
module bsr_ctrl
  import bsr_pkg::*;
(
  input  logic        captureDr,
  input  logic        shiftDr,
  input  logic        updateDr,
  input  logic        testMode,
  output bsrStrobes_t strb
);
  always_comb begin
    strb.capture = captureDr;
    // capture takes precedence over shift
    strb.shift   = shiftDr & ~captureDr;
    strb.update  = updateDr;
    strb.testOn  = testMode;
  end
endmodule

// File: rtl/bsr_datapath.sv
module bsr_datapath
  import bsr_pkg::*;
#(
  parameter int NUM_IN    = 2,
  parameter int NUM_OUT   = 2,
  parameter int NUM_BIDIR = 1
) (
  input  logic                 tck,
  input  logic                 trstN,
  input  logic                 tdi,
  input  bsrStrobes_t          strb,
  input  logic [NUM_OUT-1:0]   coreOut,
  input  logic [NUM_IN-1:0]    padIn,
  input  logic [NUM_BIDIR-1:0] coreBiOut,
  input  logic [NUM_BIDIR-1:0] coreBiOe,
  input  logic [NUM_BIDIR-1:0] padBiIn,
  output logic [NUM_OUT-1:0]   padOut,
  output logic [NUM_BIDIR-1:0] padBiOut,
  output logic [NUM_BIDIR-1:0] padBiOe,
  output logic [NUM_IN-1:0]    coreIn,
  output logic [NUM_BIDIR-1:0] coreBiIn,
  output logic                 tdo
);
  localparam int OUT_BASE  = NUM_IN;
  localparam int BIDI_BASE = NUM_IN + NUM_OUT;
  localparam int CHAIN_LEN = NUM_IN + NUM_OUT + 2 * NUM_BIDIR;

  logic [CHAIN_LEN-1:0] capSrc;
  logic [CHAIN_LEN-1:0] capReg;
  logic [CHAIN_LEN-1:0] updReg;

  // Input cells: observe the pad, optionally feed the core from update.
  for (genvar i = 0; i < NUM_IN; i++) begin : g_inCell
    assign capSrc[i] = padIn[i];
    assign coreIn[i] = strb.testOn ? updReg[i] : padIn[i];
  end

  // Output cells: observe the core value, drive the pad from update.
  for (genvar j = 0; j < NUM_OUT; j++) begin : g_outCell
    assign capSrc[OUT_BASE + j] = coreOut[j];
    assign padOut[j] = strb.testOn ? updReg[OUT_BASE + j] : coreOut[j];
  end

  // Bidirectional pins: data cell then enable cell.
  for (genvar k = 0; k < NUM_BIDIR; k++) begin : g_bidiCell
    localparam int DATA_POS = BIDI_BASE + 2 * k;
    localparam int OE_POS   = BIDI_BASE + 2 * k + 1;
    assign capSrc[DATA_POS] = padBiIn[k];
    assign capSrc[OE_POS]   = coreBiOe[k];
    assign padBiOut[k] = strb.testOn ? updReg[DATA_POS] : coreBiOut[k];
    assign padBiOe[k]  = strb.testOn ? updReg[OE_POS]   : coreBiOe[k];
    assign coreBiIn[k] = padBiIn[k];
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      capReg <= '0;
    end else if (strb.capture) begin
      capReg <= capSrc;
    end else if (strb.shift) begin
      capReg <= {capReg[CHAIN_LEN-2:0], tdi};
    end
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      updReg <= '0;
    end else if (strb.update) begin
      updReg <= capReg;
    end
  end

  assign tdo = capReg[CHAIN_LEN-1];
endmodule

// File: rtl/bsr_top.sv
module bsr_top
  import bsr_pkg::*;
#(
  parameter int NUM_IN    = 2,
  parameter int NUM_OUT   = 2,
  parameter int NUM_BIDIR = 1
) (
  input  logic                 tck,
  input  logic                 trstN,
  input  logic                 tdi,
  input  logic                 captureDr,
  input  logic                 shiftDr,
  input  logic                 updateDr,
  input  logic                 testMode,
  input  logic [NUM_OUT-1:0]   coreOut,
  input  logic [NUM_IN-1:0]    padIn,
  input  logic [NUM_BIDIR-1:0] coreBiOut,
  input  logic [NUM_BIDIR-1:0] coreBiOe,
  input  logic [NUM_BIDIR-1:0] padBiIn,
  output logic [NUM_OUT-1:0]   padOut,
  output logic [NUM_BIDIR-1:0] padBiOut,
  output logic [NUM_BIDIR-1:0] padBiOe,
  output logic [NUM_IN-1:0]    coreIn,
  output logic [NUM_BIDIR-1:0] coreBiIn,
  output logic                 tdo
);
  bsrStrobes_t strb;

  bsr_ctrl u_ctrl (
    .captureDr (captureDr),
    .shiftDr   (shiftDr),
    .updateDr  (updateDr),
    .testMode  (testMode),
    .strb      (strb)
  );

  bsr_datapath #(
    .NUM_IN    (NUM_IN),
    .NUM_OUT   (NUM_OUT),
    .NUM_BIDIR (NUM_BIDIR)
  ) u_dp (
    .tck       (tck),
    .trstN     (trstN),
    .tdi       (tdi),
    .strb      (strb),
    .coreOut   (coreOut),
    .padIn     (padIn),
    .coreBiOut (coreBiOut),
    .coreBiOe  (coreBiOe),
    .padBiIn   (padBiIn),
    .padOut    (padOut),
    .padBiOut  (padBiOut),
    .padBiOe   (padBiOe),
    .coreIn    (coreIn),
    .coreBiIn  (coreBiIn),
    .tdo       (tdo)
  );
endmodule

// File: rtl/bsr_checker.sv
module bsr_checker #(
  parameter int NUM_IN    = 2,
  parameter int NUM_OUT   = 2,
  parameter int NUM_BIDIR = 1
) (
  input logic                 tck,
  input logic                 trstN,
  input logic                 captureDr,
  input logic                 shiftDr,
  input logic                 updateDr,
  input logic                 testMode,
  input logic [NUM_OUT-1:0]   coreOut,
  input logic [NUM_IN-1:0]    padIn,
  input logic [NUM_BIDIR-1:0] coreBiOut,
  input logic [NUM_BIDIR-1:0] coreBiOe,
  input logic [NUM_BIDIR-1:0] padBiIn,
  input logic [NUM_OUT-1:0]   padOut,
  input logic [NUM_BIDIR-1:0] padBiOut,
  input logic [NUM_BIDIR-1:0] padBiOe,
  input logic [NUM_IN-1:0]    coreIn,
  input logic [NUM_BIDIR-1:0] coreBiIn,
  input logic                 tdo
);
  AST_PASS_THROUGH: assert property (@(posedge tck) disable iff (!trstN)
    !testMode |-> (padOut == coreOut && padBiOut == coreBiOut && padBiOe == coreBiOe
                   && coreIn == padIn && coreBiIn == padBiIn)); // R1

  AST_CAPTURE_TO_TDO: assert property (@(posedge tck) disable iff (!trstN)
    captureDr |=> (tdo == $past(coreBiOe[NUM_BIDIR-1]))); // R2

  AST_PADS_HOLD: assert property (@(posedge tck) disable iff (!trstN)
    (testMode && !updateDr) |=> (!testMode || ($stable(padOut) && $stable(padBiOut)))); // R5

  AST_OE_HOLD: assert property (@(posedge tck) disable iff (!trstN)
    (testMode && !updateDr) |=> (!testMode || $stable(padBiOe))); // R7

  AST_IDLE_TDO: assert property (@(posedge tck) disable iff (!trstN)
    (!captureDr && !shiftDr) |=> $stable(tdo)); // R9
endmodule

bind bsr_top bsr_checker #(
  .NUM_IN    (NUM_IN),
  .NUM_OUT   (NUM_OUT),
  .NUM_BIDIR (NUM_BIDIR)
) u_bsrChk (
  .tck       (tck),
  .trstN     (trstN),
  .captureDr (captureDr),
  .shiftDr   (shiftDr),
  .updateDr  (updateDr),
  .testMode  (testMode),
  .coreOut   (coreOut),
  .padIn     (padIn),
  .coreBiOut (coreBiOut),
  .coreBiOe  (coreBiOe),
  .padBiIn   (padBiIn),
  .padOut    (padOut),
  .padBiOut  (padBiOut),
  .padBiOe   (padBiOe),
  .coreIn    (coreIn),
  .coreBiIn  (coreBiIn),
  .tdo       (tdo)
);

// File: tb/tb_bsr_top.sv
module tb_bsr_top;
  localparam int NI = 2;
  localparam int NO = 2;
  localparam int NB = 1;
  localparam int L  = NI + NO + 2 * NB;

  logic tck = 1'b0;
  always #5 tck = ~tck;

  logic trstN, tdi, captureDr, shiftDr, updateDr, testMode;
  logic [NO-1:0] coreOut;
  logic [NI-1:0] padIn;
  logic [NB-1:0] coreBiOut, coreBiOe, padBiIn;
  logic [NO-1:0] padOut;
  logic [NB-1:0] padBiOut, padBiOe, coreBiIn;
  logic [NI-1:0] coreIn;
  logic tdo;

  bsr_top #(.NUM_IN(NI), .NUM_OUT(NO), .NUM_BIDIR(NB)) dut (
    .tck(tck), .trstN(trstN), .tdi(tdi), .captureDr(captureDr), .shiftDr(shiftDr),
    .updateDr(updateDr), .testMode(testMode), .coreOut(coreOut), .padIn(padIn),
    .coreBiOut(coreBiOut), .coreBiOe(coreBiOe), .padBiIn(padBiIn), .padOut(padOut),
    .padBiOut(padBiOut), .padBiOe(padBiOe), .coreIn(coreIn), .coreBiIn(coreBiIn), .tdo(tdo)
  );

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  typedef struct {
    logic  bitv;
    string tag;
  } expItem_t;
  expItem_t expQ[$];

  task automatic chk(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // Monitor: compare tdo with the next expected serial bit, away from the edge.
  always @(negedge tck) begin
    expItem_t it;
    if (expQ.size() > 0) begin
      it = expQ.pop_front();
      chk(tdo === it.bitv, it.tag, {7'b0, tdo}, {7'b0, it.bitv});
    end
  end

  task automatic tick();
    @(posedge tck);
    #2;
  endtask

  // Expected capture image, chain position 0 at bit 0.
  function automatic logic [L-1:0] capOf(input logic [NI-1:0] pi, input logic [NO-1:0] co,
                                          input logic pbi, input logic cbe);
    return {cbe, pbi, co, pi};
  endfunction

  // Driver: shift a pattern in while queueing the bits expected at tdo.
  task automatic shiftAll(input logic [L-1:0] loadPat, input logic [L-1:0] expCap, input string tag);
    for (int k = 0; k < L; k++) begin
      shiftDr = 1'b1;
      tdi = loadPat[L-1-k];
      expQ.push_back('{expCap[L-1-k], tag});
      tick();
    end
    shiftDr = 1'b0;
    tdi = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: run did not finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [L-1:0] patP, patQ;
    trstN = 1'b0; tdi = 1'b0; captureDr = 1'b0; shiftDr = 1'b0; updateDr = 1'b0;
    testMode = 1'b0; coreOut = 2'b10; padIn = 2'b01; coreBiOut = 1'b1; coreBiOe = 1'b1;
    padBiIn = 1'b0;
    #1;
    chk(padOut == 2'b10 && padBiOut == 1'b1 && padBiOe == 1'b1 && coreIn == 2'b01,
        "R1 reset pass-through", {2'b0, padOut, padBiOut, padBiOe, coreIn}, 8'b00101101);
    testMode = 1'b1;
    #1;
    chk(padOut == 2'b00 && padBiOe == 1'b0 && coreIn == 2'b00 && tdo == 1'b0,
        "R10 reset state", {1'b0, padOut, padBiOut, padBiOe, coreIn, tdo}, 8'b0);
    tick();
    trstN = 1'b1;
    tick();

    // R1: transparency under several patterns
    testMode = 1'b0;
    for (int v = 0; v < 4; v++) begin
      coreOut = v[1:0]; padIn = ~v[1:0]; coreBiOut = v[0]; coreBiOe = v[1]; padBiIn = ~v[0];
      #1;
      chk(padOut == coreOut && padIn == coreIn && padBiOut == coreBiOut &&
          padBiOe == coreBiOe && coreBiIn == padBiIn, "R1 pass-through",
          {1'b0, padOut, coreIn, padBiOut, padBiOe, coreBiIn},
          {1'b0, coreOut, padIn, coreBiOut, coreBiOe, padBiIn});
      tick();
    end

    // R2/R3: capture a known image and shift it out while loading patP
    testMode = 1'b1;
    padIn = 2'b10; coreOut = 2'b01; padBiIn = 1'b1; coreBiOe = 1'b0; coreBiOut = 1'b0;
    captureDr = 1'b1; tick(); captureDr = 1'b0;
    patP = 6'b101101;
    shiftAll(patP, capOf(2'b10, 2'b01, 1'b1, 1'b0), "R2 R3 capture/shift");
    chk(padOut == 2'b00 && padBiOe == 1'b0 && padBiOut == 1'b0 && coreIn == 2'b00,
        "R5 hold during shift", {2'b0, padOut, padBiOut, padBiOe, coreIn}, 8'b0);

    // R4/R6/R7: commit and observe mapping
    updateDr = 1'b1; tick(); updateDr = 1'b0;
    chk(padOut == patP[3:2], "R4 R6 padOut", {6'b0, padOut}, {6'b0, patP[3:2]});
    chk(coreIn == patP[1:0], "R6 coreIn", {6'b0, coreIn}, {6'b0, patP[1:0]});
    chk(padBiOut == patP[4] && padBiOe == patP[5], "R7 bidir drive",
        {6'b0, padBiOut, padBiOe}, {6'b0, patP[4], patP[5]});

    // R3/R9: chain still holds patP; shift it out loading patQ
    patQ = 6'b010011;
    shiftAll(patQ, patP, "R3 R9 chain contents");
    chk(padOut == patP[3:2] && padBiOe == patP[5], "R5 hold after shift",
        {5'b0, padOut, padBiOe}, {5'b0, patP[3:2], patP[5]});
    updateDr = 1'b1; tick(); updateDr = 1'b0;
    chk(padOut == patQ[3:2] && coreIn == patQ[1:0] && padBiOut == patQ[4] && padBiOe == patQ[5],
        "R4 R6 R7 second update", {2'b0, padOut, coreIn, padBiOut, padBiOe},
        {2'b0, patQ[3:2], patQ[1:0], patQ[4], patQ[5]});

    // R1 with non-zero update state, then R5 hold across mode change
    testMode = 1'b0; coreOut = 2'b10; padIn = 2'b01; coreBiOut = 1'b0; coreBiOe = 1'b1;
    #1;
    chk(padOut == 2'b10 && coreIn == 2'b01 && padBiOut == 1'b0 && padBiOe == 1'b1,
        "R1 pass-through over loaded cells", {2'b0, padOut, coreIn, padBiOut, padBiOe}, 8'b00100101);
    tick();
    testMode = 1'b1;
    #1;
    chk(padOut == patQ[3:2] && padBiOe == patQ[5], "R5 update retained",
        {5'b0, padOut, padBiOe}, {5'b0, patQ[3:2], patQ[5]});

    // R8: capture wins over simultaneous shift; R9: idle holds
    padIn = 2'b01; coreOut = 2'b11; padBiIn = 1'b0; coreBiOe = 1'b1;
    captureDr = 1'b1; shiftDr = 1'b1; tdi = 1'b0; tick();
    captureDr = 1'b0; shiftDr = 1'b0;
    padIn = 2'b10; coreOut = 2'b00; padBiIn = 1'b1; coreBiOe = 1'b0;
    tick(); tick(); tick();
    shiftAll(6'b0, capOf(2'b01, 2'b11, 1'b0, 1'b1), "R8 R9 capture priority and hold");
    chk(padOut == patQ[3:2], "R5 no update without strobe", {6'b0, padOut}, {6'b0, patQ[3:2]});

    // R10: reset mid-run clears update state
    trstN = 1'b0;
    #1;
    chk(padBiOe == 1'b0 && padOut == 2'b00 && coreIn == 2'b00 && padBiOut == 1'b0,
        "R10 reset clears drives", {2'b0, padOut, coreIn, padBiOut, padBiOe}, 8'b0);
    tick();

    done = 1'b1;
    summary();
    $finish;
  end
endmodule